// File: doc/BRIEF.md
# Self-Starting Modulo-6 Counter

This block is a three-bit synchronous counter that cycles through the values zero to five and then returns to zero. Three flip-flops hold eight possible codes, but only six belong to the counting cycle. The remaining two codes, 110 and 111, are not left undefined. Each one has an explicit next state of 000. A bad power-up value or a disturbed register therefore rejoins the normal cycle after a single enabled clock.

An enable input lets the counter advance only on chosen cycles. A terminal-count flag marks the last value of the cycle, so the flag can be used to enable a following stage. A debug port writes any of the eight codes into the register. This lets a test place the counter on an unused code and watch it recover. Reset is synchronous and active low.

Top module: `selfstart_mod6_counter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `count` becomes 000 after that edge and `tc` is low.
- R2: With reset inactive, `dbg_force` low and `en` high, a count of 000 through 100 advances by exactly one at each rising edge.
- R3: With reset inactive, `dbg_force` low and `en` high, a count of 101 becomes 000 at the next rising edge.
- R4: With reset inactive, `dbg_force` low and `en` high, each unused code (110 or 111) becomes 000 at the next rising edge.
- R5: With reset inactive, `dbg_force` low and `en` low, `count` keeps its value across the edge, and this includes the unused codes 110 and 111.
- R6: `tc` is high exactly while `count` equals 101, and it is low for all other seven codes.
- R7: When `dbg_force` is high at a rising edge and reset is inactive, `count` takes the value of `dbg_code`, whatever the level of `en`. Reset takes priority over the debug write, and the debug write takes priority over counting.
- R8: Starting from any of the eight codes with `en` held high, the counter is on a valid code (000 to 101) after at most one edge, and then visits all six valid codes in ascending order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Count enable, active high |
| dbg_force | input | 1 | Debug write strobe, active high |
| dbg_code | input | 3 | Code written into the register when `dbg_force` is high |
| count | output | 3 | Current counter state |
| tc | output | 1 | High while `count` is 101 |

## Verification
The debug port places the counter on each of the eight codes in turn. From each code, the bench applies two disabled clocks and then one enabled clock. The disabled clocks check holding, including holding on an unused code. The enabled clock separates the ordinary increment, the wrap from 101, and the recovery from 110 and 111. A long run from 111 with the counter enabled checks the full recovery path and the ascending order of the cycle. Cycles that combine the debug strobe with enable low, and reset with the debug strobe, check the priority order.

// File: rtl/selfstart_pkg.sv
// Package: shared widths, codes and the state type for the modulo-6 counter.
// Assumes: the modulus is fixed at six; these constants only name it.
package selfstart_pkg;
    localparam int CNT_W     = 3;
    localparam int LAST_VAL  = 5;
    localparam int NUM_CODES = 1 << CNT_W;

    typedef logic [CNT_W-1:0] code_t;

    localparam code_t ZERO_CODE = '0;
    localparam code_t LAST_CODE = code_t'(LAST_VAL);
endpackage

// File: rtl/mod6_next.sv
// Module: next-state logic for the counter.
// It gives the successor of every one of the eight codes. Codes below the
// last value step up by one. The last value and both unused codes go to zero.
// Assumes: the caller applies enable, debug write and reset.
module mod6_next
    import selfstart_pkg::*;
(
    input  code_t cur,
    output code_t nxt
);
    // Purpose: choose between increment and return-to-zero.
    always_comb begin
        if (cur < LAST_CODE) begin
            nxt = cur + code_t'(1);
        end else begin
            nxt = ZERO_CODE;
        end
    end
endmodule

// File: rtl/mod6_state_reg.sv
// Module: state register with a priority-ordered update.
// The order is reset first, then the debug write, then counting, then hold.
// Assumes: rst_n is already synchronous to clk.
module mod6_state_reg
    import selfstart_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  dbg_force,
    input  code_t dbg_code,
    input  code_t step_val,
    output code_t state_q
);
    // Purpose: register the next state according to the priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ZERO_CODE;
        end else if (dbg_force) begin
            state_q <= dbg_code;
        end else if (en) begin
            state_q <= step_val;
        end
    end
endmodule

// File: rtl/mod6_tc_decode.sv
// Module: terminal-count decoder.
// The flag is high only on the last value of the cycle.
// Assumes: the input is the registered state, so the flag has no glitches
// beyond those of a single compare.
module mod6_tc_decode
    import selfstart_pkg::*;
(
    input  code_t cur,
    output logic  at_last
);
    // Purpose: compare the state with the last value.
    always_comb begin
        at_last = (cur == LAST_CODE);
    end
endmodule

// File: rtl/selfstart_mod6_counter.sv
// Module: top of the self-starting modulo-6 counter.
// It connects the next-state logic, the state register and the
// terminal-count decoder.
// Assumes: one clock domain and a synchronous active-low reset.
module selfstart_mod6_counter
    import selfstart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dbg_force,
    input  logic [CNT_W-1:0] dbg_code,
    output logic [CNT_W-1:0] count,
    output logic             tc
);
    code_t state_q;
    code_t step_val;

    mod6_next u_next (
        .cur (state_q),
        .nxt (step_val)
    );

    mod6_state_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .dbg_force (dbg_force),
        .dbg_code  (dbg_code),
        .step_val  (step_val),
        .state_q   (state_q)
    );

    mod6_tc_decode u_tc (
        .cur     (state_q),
        .at_last (tc)
    );

    assign count = state_q;
endmodule

// File: rtl/selfstart_mod6_checker.sv
// Module: assertion checker for the counter. It is attached through bind.
// Assumes: it sees only the top-level ports.
module selfstart_mod6_checker
    import selfstart_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             dbg_force,
    input logic [CNT_W-1:0] dbg_code,
    input logic [CNT_W-1:0] count,
    input logic             tc
);
    logic seen_edge;

    // Purpose: note that at least one clock edge has passed.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (count == ZERO_CODE && !tc));

    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_force && en && count < LAST_CODE) |=> count == code_t'($past(count) + code_t'(1)));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_force && en && count == LAST_CODE) |=> count == ZERO_CODE);

    assert_recover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_force && en && count > LAST_CODE) |=> count == ZERO_CODE);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_force && !en) |=> $stable(count));

    assert_tc_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge |-> (tc == (count == LAST_CODE)));

    assert_debug_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_force |=> count == $past(dbg_code));
endmodule

bind selfstart_mod6_counter selfstart_mod6_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .dbg_force (dbg_force),
    .dbg_code  (dbg_code),
    .count     (count),
    .tc        (tc)
);

// File: tb/tb_selfstart_mod6_counter.sv
module tb_selfstart_mod6_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       dbg_force = 1'b0;
    logic [2:0] dbg_code = 3'd0;
    logic [2:0] count;
    logic       tc;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    selfstart_mod6_counter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .dbg_force (dbg_force),
        .dbg_code  (dbg_code),
        .count     (count),
        .tc        (tc)
    );

    function automatic logic [2:0] model_next(input logic [2:0] c);
        return (c < 3'd5) ? c + 3'd1 : 3'd0;
    endfunction

    task automatic check(input string req, input logic [2:0] exp_cnt);
        logic exp_tc;
        exp_tc = (exp_cnt == 3'd5);
        n_checks++;
        if (count !== exp_cnt || tc !== exp_tc) begin
            n_fail++;
            $display("FAIL %s: count=%0d tc=%0b expected count=%0d tc=%0b",
                     req, count, tc, exp_cnt, exp_tc);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic cyc(input logic r, input logic e, input logic f, input logic [2:0] d);
        rst_n = r; en = e; dbg_force = f; dbg_code = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [2:0] exp;
        @(negedge clk);
        cyc(1'b0, 1'b1, 1'b0, 3'd0);
        cyc(1'b0, 1'b1, 1'b0, 3'd0);
        check("R1 reset", 3'd0);

        for (int s = 0; s < 8; s++) begin
            cyc(1'b1, 1'b1, 1'b1, 3'(s));
            check("R7 debug write", 3'(s));
            cyc(1'b1, 1'b0, 1'b0, 3'd0);
            check("R5 hold", 3'(s));
            cyc(1'b1, 1'b0, 1'b0, 3'd0);
            check("R5 hold again", 3'(s));
            exp = model_next(3'(s));
            cyc(1'b1, 1'b1, 1'b0, 3'd0);
            if (s < 5)       check("R2 increment", exp);
            else if (s == 5) check("R3 wrap", exp);
            else             check("R4 recovery", exp);
            check("R6 flag", exp);
        end

        // R8: start from 111 with enable held and follow the cycle twice.
        cyc(1'b1, 1'b0, 1'b1, 3'd7);
        exp = 3'd7;
        for (int k = 0; k < 13; k++) begin
            exp = model_next(exp);
            cyc(1'b1, 1'b1, 1'b0, 3'd0);
            check("R8 recovery sequence", exp);
        end

        // R7 priority: the debug write wins over a low enable, and reset wins over the debug write.
        cyc(1'b1, 1'b0, 1'b1, 3'd6);
        check("R7 write with enable low", 3'd6);
        cyc(1'b0, 1'b1, 1'b1, 3'd4);
        check("R7 reset beats write", 3'd0);
        check("R1 reset from unused", 3'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run hung, actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule